// File: doc/BRIEF.md
# In-Order Warp Commit Queue

This block puts back the dispatch order of packet batches that are handed to parallel worker warps. When a batch is dispatched, the warp that takes it is given the next slot of a circular queue. Warps may finish in any order. Each completion carries only the warp identifier, so a small side table that is indexed by warp id turns the completion into a queue slot and marks that slot finished.

Results leave from the head of the queue only. A commit is issued while the head slot is occupied and finished. Each commit frees the slot and the warp's table entry in the same cycle, so the warp id can be allocated again.

Dispatch is refused while the queue is full, and also while the offered warp id is still in flight. A completion for a warp id that is not in flight changes nothing and raises a one-cycle error flag.

Top module: `wcq_top`

## Requirements
- R1: After a synchronous reset, `commit_valid` and `err_unknown` are 0, and `alloc_ready` is 1 for any warp id.
- R2: A dispatch is taken on a clock edge where `alloc_valid` and `alloc_ready` are both 1. `alloc_ready` is 0 while DEPTH warps are in flight.
- R3: `alloc_ready` is 0 while the offered `alloc_warp` has been dispatched and has not yet committed.
- R4: A completion (`done_valid` with `done_warp`) for an in-flight warp marks that warp's slot finished at the clock edge. If the slot is at the head, `commit_valid` is 1 with `commit_warp` equal to that warp in the next cycle.
- R5: Commits leave strictly in dispatch order. A finished warp that is not at the head produces no commit until every warp dispatched before it has committed.
- R6: At most one commit is issued per cycle. The commit is taken on the edge where `commit_valid` is 1, and it frees both the slot and the warp id. The following head commits in the next cycle if it is already finished.
- R7: A completion for a warp id that is not in flight leaves the queue unchanged. It sets `err_unknown` to 1 for exactly the following cycle.
- R8: A reset during operation discards all in-flight warps. Afterwards no commit is pending, and every warp id may be dispatched again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| alloc_valid | input | 1 | Dispatch request |
| alloc_warp | input | WID_W | Warp id taking the dispatched batch |
| alloc_ready | output | 1 | Dispatch can be taken this cycle |
| done_valid | input | 1 | Completion report from write-back |
| done_warp | input | WID_W | Warp id that completed |
| commit_valid | output | 1 | Head warp commits this cycle |
| commit_warp | output | WID_W | Warp id being committed |
| err_unknown | output | 1 | Previous cycle's completion named no in-flight warp |

## Verification
`alloc_ready` depends on the present state and on `alloc_warp` without a register between them, so it is checked in the same cycle the request is offered.

A completion takes effect at the next edge. `commit_valid` for that warp is therefore due one cycle after the completion is driven, and the next finished head follows one cycle later. `err_unknown` is also due one cycle after the unknown completion and falls one cycle after that.

The bench drives inputs just after the falling edge and samples a moment later, before the rising edge. Every check therefore sees the state left by the previous edge, and each expectation is written for the cycle count above.

// File: rtl/wcq_pkg.sv
package wcq_pkg;
    localparam int unsigned WCQ_WARPS = 32;
    localparam int unsigned WCQ_DEPTH = 16;

    // circular increment for any depth, not only powers of two
    function automatic int unsigned wcq_wrap(input int unsigned idx, input int unsigned depth);
        return (idx + 1 == depth) ? 0 : idx + 1;
    endfunction
endpackage

// File: rtl/wcq_slot_ring.sv
module wcq_slot_ring #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned WID_W = 5,
    parameter int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc_fire,
    input  logic [WID_W-1:0] alloc_warp,
    input  logic             mark_fire,
    input  logic [PTR_W-1:0] mark_slot,
    output logic             full,
    output logic [PTR_W-1:0] tail_slot,
    output logic             head_commit,
    output logic [WID_W-1:0] head_warp
);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0]            vld;
        logic [DEPTH-1:0]            fin;
        logic [DEPTH-1:0][WID_W-1:0] wid;
        logic [PTR_W-1:0]            head;
        logic [PTR_W-1:0]            tail;
        logic [CNT_W-1:0]            cnt;
    } ring_t;

    ring_t st_d, st_q;

    assign head_commit = st_q.vld[st_q.head] && st_q.fin[st_q.head];
    assign head_warp   = st_q.wid[st_q.head];
    assign full        = (st_q.cnt == CNT_W'(DEPTH));
    assign tail_slot   = st_q.tail;

    always_comb begin
        st_d = st_q;
        if (mark_fire) begin
            st_d.fin[mark_slot] = 1'b1;
        end
        if (alloc_fire) begin
            st_d.vld[st_q.tail] = 1'b1;
            st_d.fin[st_q.tail] = 1'b0;
            st_d.wid[st_q.tail] = alloc_warp;
            st_d.tail = PTR_W'(wcq_pkg::wcq_wrap(32'(st_q.tail), DEPTH));
        end
        // commit last so that freeing the head wins over any late mark
        if (head_commit) begin
            st_d.vld[st_q.head] = 1'b0;
            st_d.fin[st_q.head] = 1'b0;
            st_d.head = PTR_W'(wcq_pkg::wcq_wrap(32'(st_q.head), DEPTH));
        end
        case ({alloc_fire, head_commit})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= CNT_W'(DEPTH)); // R2
    AST_NO_ALLOC_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        alloc_fire |-> !full); // R2
    AST_HEAD_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        head_commit |=> ((DEPTH == 1) || (st_q.head != $past(st_q.head)))); // R6
    AST_MARK_LIVE_SLOT: assert property (@(posedge clk) disable iff (rst)
        mark_fire |-> st_q.vld[mark_slot]); // R4
endmodule

// File: rtl/wcq_warp_map.sv
module wcq_warp_map #(
    parameter int unsigned NUM_WARPS = 32,
    parameter int unsigned WID_W     = 5,
    parameter int unsigned PTR_W     = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc_fire,
    input  logic [WID_W-1:0] alloc_warp,
    input  logic [PTR_W-1:0] alloc_slot,
    output logic             alloc_busy,
    input  logic             free_fire,
    input  logic [WID_W-1:0] free_warp,
    output logic             free_live,
    input  logic [WID_W-1:0] look_warp,
    output logic             look_hit,
    output logic [PTR_W-1:0] look_slot
);
    typedef struct packed {
        logic [NUM_WARPS-1:0]            live;
        logic [NUM_WARPS-1:0][PTR_W-1:0] slot;
    } map_t;

    map_t st_d, st_q;

    assign alloc_busy = st_q.live[alloc_warp];
    assign free_live  = st_q.live[free_warp];
    assign look_hit   = st_q.live[look_warp];
    assign look_slot  = st_q.slot[look_warp];

    always_comb begin
        st_d = st_q;
        if (free_fire) begin
            st_d.live[free_warp] = 1'b0;
        end
        if (alloc_fire) begin
            st_d.live[alloc_warp] = 1'b1;
            st_d.slot[alloc_warp] = alloc_slot;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    AST_ALLOC_UNMAPPED: assert property (@(posedge clk) disable iff (rst)
        alloc_fire |-> !st_q.live[alloc_warp]); // R3
    AST_FREE_MAPPED: assert property (@(posedge clk) disable iff (rst)
        free_fire |-> st_q.live[free_warp]); // R6
    AST_ALLOC_SETS_LIVE: assert property (@(posedge clk) disable iff (rst)
        alloc_fire |=> st_q.live[$past(alloc_warp)]); // R2
endmodule

// File: rtl/wcq_top.sv
module wcq_top #(
    parameter int unsigned NUM_WARPS = wcq_pkg::WCQ_WARPS,
    parameter int unsigned DEPTH     = wcq_pkg::WCQ_DEPTH,
    parameter int unsigned WID_W     = $clog2(NUM_WARPS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc_valid,
    input  logic [WID_W-1:0] alloc_warp,
    output logic             alloc_ready,
    input  logic             done_valid,
    input  logic [WID_W-1:0] done_warp,
    output logic             commit_valid,
    output logic [WID_W-1:0] commit_warp,
    output logic             err_unknown
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic err;
    } top_t;

    top_t st_d, st_q;

    logic             full, alloc_busy, alloc_fire;
    logic             look_hit, mark_fire, free_live;
    logic [PTR_W-1:0] tail_slot, look_slot;

    assign alloc_ready  = !full && !alloc_busy;
    assign alloc_fire   = alloc_valid && alloc_ready;
    assign mark_fire    = done_valid && look_hit;
    assign err_unknown  = st_q.err;

    wcq_slot_ring #(.DEPTH(DEPTH), .WID_W(WID_W), .PTR_W(PTR_W)) ring_i (
        .clk        (clk),
        .rst        (rst),
        .alloc_fire (alloc_fire),
        .alloc_warp (alloc_warp),
        .mark_fire  (mark_fire),
        .mark_slot  (look_slot),
        .full       (full),
        .tail_slot  (tail_slot),
        .head_commit(commit_valid),
        .head_warp  (commit_warp)
    );

    wcq_warp_map #(.NUM_WARPS(NUM_WARPS), .WID_W(WID_W), .PTR_W(PTR_W)) map_i (
        .clk        (clk),
        .rst        (rst),
        .alloc_fire (alloc_fire),
        .alloc_warp (alloc_warp),
        .alloc_slot (tail_slot),
        .alloc_busy (alloc_busy),
        .free_fire  (commit_valid),
        .free_warp  (commit_warp),
        .free_live  (free_live),
        .look_warp  (done_warp),
        .look_hit   (look_hit),
        .look_slot  (look_slot)
    );

    always_comb begin
        st_d     = st_q;
        st_d.err = done_valid && !look_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    AST_ERR_AFTER_MISS: assert property (@(posedge clk) disable iff (rst)
        err_unknown |-> $past(done_valid)); // R7
    AST_COMMIT_MAPPED: assert property (@(posedge clk) disable iff (rst)
        commit_valid |-> free_live); // R6
endmodule

// File: tb/wcq_top_tb_top.sv
module wcq_top_tb_top;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       alloc_valid = 1'b0;
    logic [4:0] alloc_warp = '0;
    logic       alloc_ready;
    logic       done_valid = 1'b0;
    logic [4:0] done_warp = '0;
    logic       commit_valid;
    logic [4:0] commit_warp;
    logic       err_unknown;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    wcq_top dut_i (
        .clk(clk), .rst(rst),
        .alloc_valid(alloc_valid), .alloc_warp(alloc_warp), .alloc_ready(alloc_ready),
        .done_valid(done_valid), .done_warp(done_warp),
        .commit_valid(commit_valid), .commit_warp(commit_warp),
        .err_unknown(err_unknown)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive inputs after the falling edge, then settle before sampling
    task automatic drive(input logic av, input int aw, input logic dv, input int dw);
        @(negedge clk);
        alloc_valid = av;
        alloc_warp  = 5'(aw);
        done_valid  = dv;
        done_warp   = 5'(dw);
        #1;
    endtask

    task automatic idle();
        drive(1'b0, 0, 1'b0, 0);
    endtask

    // commit expectation: ev = expect valid, ew = expected warp
    task automatic chk_commit(input string req, input logic ev, input int ew);
        chk(req, int'(commit_valid), int'(ev));
        if (ev) chk(req, int'(commit_warp), ew);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        idle();
        @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        do_reset();
        chk_commit("R1", 1'b0, 0);
        chk("R1", int'(err_unknown), 0);
        drive(1'b0, 17, 1'b0, 0);
        chk("R1", int'(alloc_ready), 1);
    endtask

    task automatic t_in_order();
        drive(1'b1, 3, 1'b0, 0); chk("R2", int'(alloc_ready), 1);
        drive(1'b1, 7, 1'b0, 0); chk("R2", int'(alloc_ready), 1);
        drive(1'b1, 9, 1'b0, 0); chk("R2", int'(alloc_ready), 1);
        drive(1'b0, 0, 1'b1, 9); chk_commit("R5", 1'b0, 0);
        drive(1'b0, 0, 1'b1, 7); chk_commit("R5", 1'b0, 0);
        drive(1'b0, 0, 1'b1, 3); chk_commit("R5", 1'b0, 0);
        idle(); chk_commit("R4", 1'b1, 3);
        idle(); chk_commit("R6", 1'b1, 7);
        idle(); chk_commit("R6", 1'b1, 9);
        idle(); chk_commit("R6", 1'b0, 0);
    endtask

    task automatic t_dup();
        drive(1'b1, 5, 1'b0, 0); chk("R2", int'(alloc_ready), 1);
        drive(1'b1, 5, 1'b0, 0); chk("R3", int'(alloc_ready), 0);
        drive(1'b0, 5, 1'b1, 5); chk("R3", int'(alloc_ready), 0);
        drive(1'b0, 5, 1'b0, 0); chk_commit("R4", 1'b1, 5);
        chk("R3", int'(alloc_ready), 0);
        drive(1'b0, 5, 1'b0, 0); chk("R6", int'(alloc_ready), 1);
        chk_commit("R6", 1'b0, 0);
    endtask

    task automatic t_full();
        for (int i = 0; i < DEPTH; i++) begin
            drive(1'b1, i, 1'b0, 0);
            chk("R2", int'(alloc_ready), 1);
        end
        drive(1'b1, 20, 1'b0, 0); chk("R2", int'(alloc_ready), 0);
        drive(1'b0, 20, 1'b1, 0); chk("R2", int'(alloc_ready), 0);
        drive(1'b0, 20, 1'b0, 0); chk("R2", int'(alloc_ready), 0);
        chk_commit("R4", 1'b1, 0);
        drive(1'b1, 20, 1'b0, 0); chk("R2", int'(alloc_ready), 1);
        for (int k = 0; k < DEPTH; k++) begin
            int w = (k < DEPTH - 1) ? k + 1 : 20;
            drive(1'b0, 0, 1'b1, w);
            if (k == 0) chk_commit("R5", 1'b0, 0);
            else        chk_commit("R5", 1'b1, k);
        end
        idle(); chk_commit("R6", 1'b1, 20);
        idle(); chk_commit("R6", 1'b0, 0);
    endtask

    task automatic t_unknown();
        drive(1'b0, 0, 1'b1, 25); chk("R7", int'(err_unknown), 0);
        idle(); chk("R7", int'(err_unknown), 1);
        chk_commit("R7", 1'b0, 0);
        drive(1'b0, 25, 1'b0, 0); chk("R7", int'(err_unknown), 0);
        chk("R7", int'(alloc_ready), 1);
        drive(1'b1, 11, 1'b0, 0);
        drive(1'b0, 0, 1'b1, 12); chk_commit("R7", 1'b0, 0);
        idle(); chk("R7", int'(err_unknown), 1);
        chk_commit("R7", 1'b0, 0);
        drive(1'b0, 0, 1'b1, 11); chk("R7", int'(err_unknown), 0);
        idle(); chk_commit("R7", 1'b1, 11);
        idle();
    endtask

    task automatic t_reset_mid();
        drive(1'b1, 4, 1'b0, 0);
        drive(1'b1, 6, 1'b0, 0);
        drive(1'b0, 0, 1'b1, 4);
        do_reset();
        chk_commit("R8", 1'b0, 0);
        drive(1'b0, 6, 1'b0, 0); chk("R8", int'(alloc_ready), 1);
        chk_commit("R8", 1'b0, 0);
        drive(1'b0, 0, 1'b1, 6); idle();
        chk("R8", int'(err_unknown), 1);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_in_order();
                t_dup();
                t_full();
                t_unknown();
                t_reset_mid();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_err++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule